// File: doc/BRIEF.md
# Key Wrap Round Sequencer

This block runs the iteration loop of the 64-bit-block key wrap and key unwrap procedures over an object held in a local word store. Software prepares the object in the store (block `i` at address `i-1`), supplies the 64-bit starting integrity value, the number of 64-bit blocks `n` (the integrity block is not counted) and the direction, then pulses `start`. The block does not compute the starting integrity value, does no padding and does no key handling. The block cipher sits outside, behind a request/ready port. The `cph_inverse` output tells the cipher which direction to run.

For every step the sequencer reads one 64-bit block from the store. It presents the 128-bit concatenation of the integrity half and that block to the cipher, and waits for the cipher's answer. It then writes the new low half back to the same address and keeps the new high half as the running integrity value. A step counter `t`, equal to `n*j + i`, is zero-extended and folded into the integrity half. Wrap folds it in after encryption. Unwrap folds it in before decryption. Six passes cover the object. When the last block is written, `done` pulses and the final integrity value stays on `a_out`.

Top module: `kw_round_seq`

## Requirements
- R1: While idle, a `start` pulse with `n_blocks` of 2 or more makes `busy` high in the following cycle and loads `a_out` with `a_init`. The direction is latched from `unwrap` (0 = wrap, 1 = unwrap).
- R2: Wrap visits blocks with the pass index j rising from 0 to 5 and, within a pass, i rising from 1 to n. Unwrap uses j falling from 5 to 0 and i falling from n to 1. Block i lives at store address i-1.
- R3: A wrap step sends {A, R[i]} (A in bits 127:64) with `cph_inverse` = 0. A becomes the upper 64 bits of the answer XOR t, and R[i] the lower 64 bits, where t = n*j + i zero-extended to 64 bits.
- R4: An unwrap step sends {A XOR t, R[i]} with `cph_inverse` = 1. A becomes the upper 64 bits of the answer and R[i] the lower 64 bits. Unwrapping a wrapped object restores the original blocks and starting value.
- R5: Each step does exactly one store read, then one cipher request, then one store write of the new R[i] to the read address. Read data is taken in the cycle after `mem_rd_en`. A read and a write never happen in the same cycle, and no store or cipher access happens unless `busy` is high.
- R6: `cph_req` stays high, with `cph_din` unchanged, until a cycle in which `cph_ready` is high. `cph_dout` is taken in that cycle.
- R7: `done` is high for exactly one cycle, right after the last write, while `busy` is low. `a_out` then keeps the final value until the next accepted start.
- R8: A `start` pulse while `busy` is high, or in the `done` cycle, has no effect: the running sequence, its direction and its results are unchanged.
- R9: A start with `n_blocks` below 2 gives `done` together with `err` in the next cycle, with no store or cipher access.
- R10: After reset `busy`, `done`, `err`, `cph_req`, `mem_rd_en` and `mem_wr_en` are low and `a_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (sampled only while idle) |
| unwrap | input | 1 | Direction at start: 0 wrap, 1 unwrap |
| a_init | input | 64 | Starting integrity value |
| n_blocks | input | 14 | Object length n in 64-bit blocks |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With `done`: length was below 2 |
| a_out | output | 64 | Running / final integrity value |
| mem_rd_en | output | 1 | Store read strobe |
| mem_wr_en | output | 1 | Store write strobe |
| mem_addr | output | 13 | Store word address (block index minus one) |
| mem_wdata | output | 64 | Store write data |
| mem_rdata | input | 64 | Store read data, valid the cycle after the strobe |
| cph_req | output | 1 | Cipher request |
| cph_inverse | output | 1 | Cipher direction: 1 = decrypt |
| cph_din | output | 128 | Cipher input block |
| cph_ready | input | 1 | Cipher answer valid |
| cph_dout | input | 128 | Cipher output block |

## Verification
The hardest situation to reach is a `start` that arrives while a sequence is half done, or in the single `done` cycle. In either case the latched direction and length must survive, even though the new request carries the opposite direction and another length. The stimulus pulses `start` in the middle of one wrap run, with conflicting values on every input. It pulses it again in the exact completion cycle of an unwrap run. The reference model then requires every later cipher input and store write to match the first request alone. Random cipher latencies, from zero upward, keep the request held across several cycles. A wrap followed by an unwrap of the same object checks that the two directions invert each other.

// File: rtl/kw_pkg.sv
// Shared types for the key wrap round sequencer.
package kw_pkg;

    // Sequencer phases: one pass through READ..WRITE is one step.
    typedef enum logic [2:0] {
        KW_IDLE,
        KW_READ,
        KW_CAPT,
        KW_CALL,
        KW_WRITE,
        KW_FIN
    } kw_state_e;

endpackage

// File: rtl/kw_step_ctr.sv
// Loop counters for the six-pass schedule.
// Holds the length n, the pass index j, the block index i and the running
// step number t = n*j + i. Assumes 2 <= n <= 2**(N_W-1); the caller filters
// shorter lengths before asserting load.
module kw_step_ctr #(
    parameter int N_W    = 14,
    parameter int PASSES = 6,
    localparam int J_W   = $clog2(PASSES),
    localparam int T_W   = N_W + J_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           adv,
    input  logic           unwrap,
    input  logic [N_W-1:0] n_in,
    output logic [N_W-1:0] idx,
    output logic [T_W-1:0] t,
    output logic           last
);

    localparam logic [J_W-1:0] LAST_PASS = J_W'(PASSES - 1);
    localparam logic [N_W-1:0] ONE_N     = N_W'(1);

    logic [N_W-1:0] n_q;
    logic [J_W-1:0] pass_q;

    // Load start values for the chosen direction, then step through the loops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= '0;
            pass_q <= '0;
            idx    <= '0;
            t      <= '0;
        end else if (load) begin
            n_q <= n_in;
            if (unwrap) begin
                pass_q <= LAST_PASS;
                idx    <= n_in;
                t      <= T_W'(n_in) * T_W'(PASSES);
            end else begin
                pass_q <= '0;
                idx    <= ONE_N;
                t      <= T_W'(1);
            end
        end else if (adv) begin
            if (unwrap) begin
                t <= t - T_W'(1);
                if (idx == ONE_N) begin
                    idx    <= n_q;
                    pass_q <= pass_q - J_W'(1);
                end else begin
                    idx <= idx - ONE_N;
                end
            end else begin
                t <= t + T_W'(1);
                if (idx == n_q) begin
                    idx    <= ONE_N;
                    pass_q <= pass_q + J_W'(1);
                end else begin
                    idx <= idx + ONE_N;
                end
            end
        end
    end

    // Final step of the schedule for the current direction.
    always_comb begin
        if (unwrap) last = (pass_q == '0) && (idx == ONE_N);
        else        last = (pass_q == LAST_PASS) && (idx == n_q);
    end

endmodule

// File: rtl/kw_ab_regs.sv
// Integrity half (A) and data half (R) registers with the step-counter fold.
// Assumes t is narrower than a half block; it is zero-extended before the XOR.
module kw_ab_regs #(
    parameter int BLK_W = 64,
    parameter int T_W   = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BLK_W-1:0]   a_init,
    input  logic               cap,
    input  logic [BLK_W-1:0]   r_in,
    input  logic               take,
    input  logic               unwrap,
    input  logic [T_W-1:0]     t,
    input  logic [2*BLK_W-1:0] dout,
    output logic [BLK_W-1:0]   a_q,
    output logic [BLK_W-1:0]   r_q,
    output logic [2*BLK_W-1:0] din
);

    logic [BLK_W-1:0] t_ext;
    logic [BLK_W-1:0] d_hi;
    logic [BLK_W-1:0] d_lo;

    assign t_ext = BLK_W'(t);
    assign d_hi  = dout[2*BLK_W-1:BLK_W];
    assign d_lo  = dout[BLK_W-1:0];

    // Cipher input: unwrap folds t in before the call, wrap does not.
    assign din = {(unwrap ? (a_q ^ t_ext) : a_q), r_q};

    // Load A at start, capture R from the store, absorb the cipher answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            r_q <= '0;
        end else begin
            if (load) a_q <= a_init;
            if (cap)  r_q <= r_in;
            if (take) begin
                a_q <= unwrap ? d_hi : (d_hi ^ t_ext);
                r_q <= d_lo;
            end
        end
    end

endmodule

// File: rtl/kw_round_seq.sv
// Key wrap / unwrap round sequencer (top).
// Walks the six-pass schedule over blocks held in a one-cycle-latency store,
// calling an external block cipher through a request/ready port for each step.
// Assumes the store returns data the cycle after mem_rd_en, and that the
// cipher holds cph_dout valid in the cycle cph_ready is high.
module kw_round_seq #(
    parameter int BLK_W  = 64,
    parameter int ADDR_W = 13,
    parameter int PASSES = 6,
    localparam int N_W   = ADDR_W + 1,
    localparam int T_W   = N_W + $clog2(PASSES),
    localparam int DAT_W = 2 * BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              unwrap,
    input  logic [BLK_W-1:0]  a_init,
    input  logic [N_W-1:0]    n_blocks,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [BLK_W-1:0]  a_out,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic [BLK_W-1:0]  mem_rdata,
    output logic              cph_req,
    output logic              cph_inverse,
    output logic [DAT_W-1:0]  cph_din,
    input  logic              cph_ready,
    input  logic [DAT_W-1:0]  cph_dout
);

    import kw_pkg::*;

    kw_state_e        state_q, state_d;
    logic             mode_q;
    logic             bad_q;
    logic             accept, n_ok, take, adv, last, ctr_mode;
    logic [N_W-1:0]   idx;
    logic [T_W-1:0]   t;
    logic [BLK_W-1:0] r_q;

    assign accept   = (state_q == KW_IDLE) && start;
    assign n_ok     = n_blocks >= N_W'(2);
    assign take     = (state_q == KW_CALL) && cph_ready;
    assign adv      = (state_q == KW_WRITE) && !last;
    assign ctr_mode = (state_q == KW_IDLE) ? unwrap : mode_q;

    // Next-phase selection for the step loop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KW_IDLE:  if (start) state_d = n_ok ? KW_READ : KW_FIN;
            KW_READ:  state_d = KW_CAPT;
            KW_CAPT:  state_d = KW_CALL;
            KW_CALL:  if (cph_ready) state_d = KW_WRITE;
            KW_WRITE: state_d = last ? KW_FIN : KW_READ;
            KW_FIN:   state_d = KW_IDLE;
            default:  state_d = KW_IDLE;
        endcase
    end

    // Phase register plus direction and length-fault latches taken at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KW_IDLE;
            mode_q  <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mode_q <= unwrap;
                bad_q  <= !n_ok;
            end
        end
    end

    kw_step_ctr #(
        .N_W    (N_W),
        .PASSES (PASSES)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept && n_ok),
        .adv    (adv),
        .unwrap (ctr_mode),
        .n_in   (n_blocks),
        .idx    (idx),
        .t      (t),
        .last   (last)
    );

    kw_ab_regs #(
        .BLK_W (BLK_W),
        .T_W   (T_W)
    ) u_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .a_init (a_init),
        .cap    (state_q == KW_CAPT),
        .r_in   (mem_rdata),
        .take   (take),
        .unwrap (mode_q),
        .t      (t),
        .dout   (cph_dout),
        .a_q    (a_out),
        .r_q    (r_q),
        .din    (cph_din)
    );

    assign busy        = (state_q == KW_READ) || (state_q == KW_CAPT) ||
                         (state_q == KW_CALL) || (state_q == KW_WRITE);
    assign done        = (state_q == KW_FIN);
    assign err         = done && bad_q;
    assign mem_rd_en   = (state_q == KW_READ);
    assign mem_wr_en   = (state_q == KW_WRITE);
    assign mem_addr    = ADDR_W'(idx - N_W'(1));
    assign mem_wdata   = r_q;
    assign cph_req     = (state_q == KW_CALL);
    assign cph_inverse = mode_q;

endmodule

// File: rtl/kw_round_seq_chk.sv
// Port-level property checker for kw_round_seq, attached by bind below.
module kw_round_seq_chk #(
    parameter int BLK_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [BLK_W-1:0]   a_out,
    input logic               mem_rd_en,
    input logic               mem_wr_en,
    input logic               cph_req,
    input logic               cph_inverse,
    input logic [2*BLK_W-1:0] cph_din,
    input logic               cph_ready
);

    // R5: store and cipher are touched only while a sequence runs.
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en && !cph_req));

    // R5: never a read and a write in one cycle.
    assert_rw_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R6: an unanswered request is held with a steady payload.
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cph_req && !cph_ready) |=> (cph_req && $stable(cph_din)));

    // R7: completion is a single-cycle pulse outside busy.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R7: the integrity value holds while idle without a start.
    assert_a_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(a_out));

    // R8: a start during a run keeps it running in the same direction.
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !mem_wr_en) |=> (busy && $stable(cph_inverse)));

    // R9: the length fault appears only with completion.
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

endmodule

bind kw_round_seq kw_round_seq_chk #(.BLK_W(BLK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .a_out       (a_out),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .cph_req     (cph_req),
    .cph_inverse (cph_inverse),
    .cph_din     (cph_din),
    .cph_ready   (cph_ready)
);

// File: tb/kw_round_seq_bench.sv
// Bench for kw_round_seq: behavioural model of the schedule, a small store
// and an invertible cipher stand-in with variable latency.
module kw_round_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] KEYMIX = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          unwrap = 1'b0;
    logic [63:0]   a_init = '0;
    logic [13:0]   n_blocks = '0;
    logic          busy, done, err;
    logic [63:0]   a_out;
    logic          mem_rd_en, mem_wr_en;
    logic [12:0]   mem_addr;
    logic [63:0]   mem_wdata;
    logic [63:0]   mem_rdata = '0;
    logic          cph_req, cph_inverse;
    logic [127:0]  cph_din;
    logic          cph_ready = 1'b0;
    logic [127:0]  cph_dout = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [63:0]  mem [16];
    logic [63:0]  ref_mem [16];
    logic [127:0] q_din[$];
    logic [12:0]  q_raddr[$];
    logic [12:0]  q_waddr[$];
    logic [63:0]  q_wdata[$];
    logic [63:0]  exp_a;
    bit           cur_uw = 1'b0;
    int           lat_mode = 0;
    int           lat_left = 0;
    int           lat_seq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kw_round_seq u_kw_round_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .unwrap(unwrap),
        .a_init(a_init), .n_blocks(n_blocks), .busy(busy), .done(done),
        .err(err), .a_out(a_out), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cph_req(cph_req), .cph_inverse(cph_inverse),
        .cph_din(cph_din), .cph_ready(cph_ready), .cph_dout(cph_dout)
    );

    function automatic logic [127:0] enc(input logic [127:0] x);
        return {x[114:0], x[127:115]} ^ KEYMIX;
    endfunction

    function automatic logic [127:0] dec(input logic [127:0] y);
        logic [127:0] z;
        z = y ^ KEYMIX;
        return {z[12:0], z[127:13]};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Behavioural schedule: fills the expectation queues and ref_mem.
    task automatic build_expect(input bit uw, input logic [63:0] a, input int n);
        logic [127:0] x, y;
        logic [63:0]  tt;
        for (int k = 0; k < 16; k++) ref_mem[k] = mem[k];
        q_din.delete(); q_raddr.delete(); q_waddr.delete(); q_wdata.delete();
        exp_a = a;
        if (n < 2) return;
        if (!uw) begin
            for (int j = 0; j < 6; j++) begin
                for (int i = 1; i <= n; i++) begin
                    tt = 64'(n * j + i);
                    x = {exp_a, ref_mem[i-1]};
                    q_din.push_back(x);
                    q_raddr.push_back(13'(i-1));
                    y = enc(x);
                    exp_a = y[127:64] ^ tt;
                    ref_mem[i-1] = y[63:0];
                    q_waddr.push_back(13'(i-1));
                    q_wdata.push_back(y[63:0]);
                end
            end
        end else begin
            for (int j = 5; j >= 0; j--) begin
                for (int i = n; i >= 1; i--) begin
                    tt = 64'(n * j + i);
                    x = {exp_a ^ tt, ref_mem[i-1]};
                    q_din.push_back(x);
                    q_raddr.push_back(13'(i-1));
                    y = dec(x);
                    exp_a = y[127:64];
                    ref_mem[i-1] = y[63:0];
                    q_waddr.push_back(13'(i-1));
                    q_wdata.push_back(y[63:0]);
                end
            end
        end
    endtask

    // Store and cipher stand-in, compared against the model on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cph_ready) begin
                cph_ready = 1'b0;
            end else if (cph_req) begin
                if (lat_left == 0) begin
                    if (q_din.size() == 0) begin
                        chk(1'b0, "R2 unexpected cipher call", cph_din, '0);
                    end else begin
                        logic [127:0] e;
                        e = q_din.pop_front();
                        chk(cph_din == e, cur_uw ? "R4 cipher input" : "R3 cipher input", cph_din, e);
                        chk(cph_inverse == cur_uw, "R4 direction flag", 128'(cph_inverse), 128'(cur_uw));
                    end
                    cph_dout  = cph_inverse ? dec(cph_din) : enc(cph_din);
                    cph_ready = 1'b1;
                    lat_left  = (lat_mode == 0) ? 0 : (lat_seq % 4);
                    lat_seq++;
                end else begin
                    lat_left--;
                end
            end
            if (mem_rd_en) begin
                if (q_raddr.size() == 0) chk(1'b0, "R2 unexpected read", 128'(mem_addr), '0);
                else begin
                    logic [12:0] ea;
                    ea = q_raddr.pop_front();
                    chk(mem_addr == ea, "R2 read order", 128'(mem_addr), 128'(ea));
                end
                mem_rdata = mem[mem_addr[3:0]];
            end
            if (mem_wr_en) begin
                if (q_waddr.size() == 0) chk(1'b0, "R5 unexpected write", 128'(mem_addr), '0);
                else begin
                    logic [12:0] ea;
                    logic [63:0] ed;
                    ea = q_waddr.pop_front();
                    ed = q_wdata.pop_front();
                    chk(mem_addr == ea, "R5 write address", 128'(mem_addr), 128'(ea));
                    chk(mem_wdata == ed, "R5 write data", 128'(mem_wdata), 128'(ed));
                end
                mem[mem_addr[3:0]] = mem_wdata;
            end
            if ((mem_rd_en || mem_wr_en || cph_req) && !busy)
                chk(1'b0, "R5 access outside busy", 128'(busy), 128'(1));
        end
    end

    task automatic run_op(input bit uw, input logic [63:0] a, input int n,
                          input int lm, input bit poke_busy, input bit poke_fin);
        int cyc;
        build_expect(uw, a, n);
        cur_uw = uw; lat_mode = lm; lat_left = 0;
        @(negedge clk);
        start = 1'b1; unwrap = uw; a_init = a; n_blocks = 14'(n);
        @(negedge clk);
        start = 1'b0;
        if (n < 2) begin
            chk(done && err && !busy, "R9 immediate fault", {125'd0, done, err, busy}, 128'b110);
            @(negedge clk);
            chk(!done && !err, "R9 fault pulse ends", {126'd0, done, err}, '0);
            return;
        end
        chk(busy && !done, "R1 busy after start", {126'd0, busy, done}, 128'b10);
        chk(a_out == a, "R1 A loaded", 128'(a_out), 128'(a));
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (poke_busy && cyc == 20) begin
                start = 1'b1; unwrap = !uw; a_init = ~a; n_blocks = 14'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (poke_busy && cyc == 21)
                chk(busy && cph_inverse == uw, "R8 start ignored while busy", 128'(busy), 128'(1));
        end
        start = 1'b0;
        if (!done) begin
            chk(1'b0, "R7 watchdog waiting for done", 128'(cyc), 128'(5000));
            return;
        end
        chk(!busy && !err, "R7 done outside busy", {126'd0, busy, err}, '0);
        chk(a_out == exp_a, uw ? "R4 final A" : "R3 final A", 128'(a_out), 128'(exp_a));
        chk(q_din.size() == 0 && q_wdata.size() == 0, "R5 all steps done",
            128'(q_din.size() + q_wdata.size()), '0);
        for (int k = 0; k < 16; k++)
            chk(mem[k] == ref_mem[k], uw ? "R4 store contents" : "R3 store contents",
                128'(mem[k]), 128'(ref_mem[k]));
        if (poke_fin) begin
            start = 1'b1; unwrap = !uw; a_init = ~a; n_blocks = 14'd4;
        end
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R7 done single cycle", 128'(done), '0);
        chk(!busy, poke_fin ? "R8 start in done cycle ignored" : "R7 idle after done", 128'(busy), '0);
        repeat (3) @(negedge clk);
        chk(a_out == exp_a && !busy, "R7 A holds", 128'(a_out), 128'(exp_a));
    endtask

    initial begin
        logic [63:0] orig [16];
        for (int k = 0; k < 16; k++) begin
            mem[k]  = 64'h1111_0000_0000_0000 * 64'(k + 1) ^ 64'(k * 977);
            orig[k] = mem[k];
        end
        repeat (4) @(negedge clk);
        chk(!busy && !done && !err && !cph_req && !mem_rd_en && !mem_wr_en,
            "R10 reset outputs", {122'd0, busy, done, err, cph_req, mem_rd_en, mem_wr_en}, '0);
        chk(a_out == '0, "R10 reset A", 128'(a_out), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10 idle after reset", {126'd0, busy, done}, '0);

        run_op(1'b0, 64'hA6A6A6A6A6A6A6A6, 2, 0, 1'b0, 1'b0);
        run_op(1'b1, exp_a, 2, 0, 1'b0, 1'b0);
        chk(a_out == 64'hA6A6A6A6A6A6A6A6, "R4 round trip A", 128'(a_out), 128'(64'hA6A6A6A6A6A6A6A6));
        chk(mem[0] == orig[0] && mem[1] == orig[1], "R4 round trip data", 128'(mem[0]), 128'(orig[0]));

        run_op(1'b0, 64'h0123456789ABCDEF, 5, 1, 1'b1, 1'b0);
        run_op(1'b1, exp_a, 5, 1, 1'b0, 1'b1);
        chk(a_out == 64'h0123456789ABCDEF, "R4 round trip A n=5", 128'(a_out), 128'(64'h0123456789ABCDEF));

        run_op(1'b0, 64'hFEDCBA9876543210, 0, 0, 1'b0, 1'b0);
        run_op(1'b1, 64'hFEDCBA9876543210, 1, 0, 1'b0, 1'b0);

        run_op(1'b0, 64'h5A5A0000FFFF1234, 16, 1, 1'b0, 1'b0);
        run_op(1'b1, 64'h0000000000000001, 16, 0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule